// File: doc/BRIEF.md
# Status Register and Write-Permission Unit

This block keeps the status state of a small serial nonvolatile memory and decides, one request at a time, whether a write may proceed. A serial controller next to it does the bit shifting and hands over already decoded pulses. There are pulses to set or clear the write-enable latch, pulses to set or clear a user flag, a request to commit an array write at a given address, and a request to commit a status write carrying a data byte. The block answers each write request with a one-cycle grant or deny pulse and always presents the formatted status byte for read-out.

The modelled nonvolatile part holds a write-protect-enable bit and a two-bit lock field. The lock field fences off the top quarter, the top half or the whole array. A granted write starts a busy window of `WR_CYCLES` clocks. The busy bit shows in the status byte for that whole window. At the end of the window the write-enable latch clears, and a status write applies its new bits. The write-protect pin works together with the protect-enable bit to freeze the status register. The permission test is made only when the request arrives, so a status write already under way still completes if the pin drops during it.

Top module: `srwp_unit`

## Requirements
- R1: The status byte is, from bit 7 down: protect-enable, flag, 0, 0, lock bit 1, lock bit 0, write-enable latch, busy. Bits 5 and 4 always read 0.
- R2: After reset the status byte is 0x00, and grant and deny are low.
- R3: A write-enable set pulse makes bit 1 read 1 on the next cycle, and a clear pulse makes it read 0. When both pulses arrive together, clear wins.
- R4: The flag set and clear pulses change bit 6 on the next cycle. A status write never alters the flag.
- R5: Any write request made while the write-enable latch is 0 is denied.
- R6: An array write is denied when the address falls in the locked range. Lock code 00 locks nothing. Code 01 locks 0x600-0x7FF. Code 10 locks 0x400-0x7FF. Code 11 locks 0x000-0x7FF.
- R7: A status write is denied when protect-enable is 1 and the pin is low. With protect-enable 0 it is allowed at either pin level, and with the pin high it is allowed.
- R8: A granted request gives a grant pulse on the cycle after the request. Busy then reads 1 for exactly `WR_CYCLES` cycles. When busy falls, the write-enable latch reads 0 and a status write has stored data bits 7, 3 and 2. Data bits 6, 5, 4, 1 and 0 are not stored.
- R9: Driving the pin low while a granted status write is busy does not stop that write.
- R10: A denied request gives a deny pulse on the next cycle. It leaves busy at 0 and leaves the write-enable latch unchanged.
- R11: While busy reads 1, every pulse and request is ignored: no grant, no deny, and no change to the latch or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_pin | input | 1 | Write-protect pin level, low means protect |
| wel_set | input | 1 | Set write-enable latch |
| wel_clr | input | 1 | Clear write-enable latch |
| flag_set | input | 1 | Set user flag |
| flag_clr | input | 1 | Clear user flag |
| arr_wr_req | input | 1 | Request to commit an array write |
| arr_wr_addr | input | ADDR_W | Array write start address |
| sr_wr_req | input | 1 | Request to commit a status write |
| sr_wr_data | input | 8 | Status write data byte |
| wr_grant | output | 1 | Write accepted, one-cycle pulse |
| wr_deny | output | 1 | Write refused, one-cycle pulse |
| status_byte | output | 8 | Formatted status byte |

## Verification
Every result appears one clock edge after the request or pulse that causes it. Grant, deny and latch or flag changes are visible after the edge that samples the input. The busy bit reads 1 from that same edge and stays up for `WR_CYCLES` edges. The status bits of a write and the cleared latch appear on the edge where busy falls. The bench drives inputs on the falling clock edge and samples on the next falling edge, so each check lands exactly one register stage after its stimulus. The busy window is walked one cycle at a time, so its length is checked to the cycle.

// File: rtl/srwp_pkg.sv
package srwp_pkg;
  typedef enum logic [1:0] {
    LOCK_NONE = 2'b00,
    LOCK_QTR  = 2'b01,
    LOCK_HALF = 2'b10,
    LOCK_ALL  = 2'b11
  } lock_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'b00,
    PEND_ARR  = 2'b01,
    PEND_SR   = 2'b10
  } pend_e;

  localparam int SB_WIP  = 0;
  localparam int SB_WEL  = 1;
  localparam int SB_BL0  = 2;
  localparam int SB_BL1  = 3;
  localparam int SB_FLAG = 6;
  localparam int SB_WPEN = 7;
endpackage

// File: rtl/srwp_lock_map.sv
module srwp_lock_map
  import srwp_pkg::*;
(
  input  lock_e      lock,
  input  logic [1:0] addr_top,
  output logic       hit
);
  always_comb begin
    unique case (lock)
      LOCK_NONE: hit = 1'b0;
      LOCK_QTR:  hit = (addr_top == 2'b11);
      LOCK_HALF: hit = addr_top[1];
      default:   hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/srwp_busy_timer.sv
module srwp_busy_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = CNT_W'(CYCLES);
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/srwp_gate.sv
module srwp_gate (
  input  logic busy,
  input  logic wel,
  input  logic wpen,
  input  logic wp_pin,
  input  logic lock_hit,
  input  logic arr_req,
  input  logic sr_req,
  output logic arr_ok,
  output logic sr_ok,
  output logic refuse
);
  logic rom_mode;

  always_comb begin
    rom_mode = wpen & ~wp_pin;
    arr_ok   = ~busy & arr_req & wel & ~lock_hit;
    sr_ok    = ~busy & sr_req & ~arr_req & wel & ~rom_mode;
    refuse   = ~busy & (arr_req | sr_req) & ~arr_ok & ~sr_ok;
  end
endmodule

// File: rtl/srwp_unit.sv
module srwp_unit
  import srwp_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int WR_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              wel_set,
  input  logic              wel_clr,
  input  logic              flag_set,
  input  logic              flag_clr,
  input  logic              arr_wr_req,
  input  logic [ADDR_W-1:0] arr_wr_addr,
  input  logic              sr_wr_req,
  input  logic [7:0]        sr_wr_data,
  output logic              wr_grant,
  output logic              wr_deny,
  output logic [7:0]        status_byte
);
  localparam int STAGE_W = 3;

  logic               wpen_q, wpen_d;
  lock_e              lock_q, lock_d;
  logic               flag_q, flag_d;
  logic               wel_q, wel_d;
  pend_e              pend_q, pend_d;
  logic [STAGE_W-1:0] stage_q, stage_d;
  logic               grant_q, deny_q;

  logic busy, done, lock_hit, arr_ok, sr_ok, refuse, accept;
  logic [4:0]        unused_sr_bits;
  logic [ADDR_W-3:0] unused_addr_low;

  assign unused_sr_bits  = {sr_wr_data[6:4], sr_wr_data[1:0]};
  assign unused_addr_low = arr_wr_addr[ADDR_W-3:0];

  srwp_lock_map u_map (
    .lock     (lock_q),
    .addr_top (arr_wr_addr[ADDR_W-1 -: 2]),
    .hit      (lock_hit)
  );

  srwp_gate u_gate (
    .busy     (busy),
    .wel      (wel_q),
    .wpen     (wpen_q),
    .wp_pin   (wp_pin),
    .lock_hit (lock_hit),
    .arr_req  (arr_wr_req),
    .sr_req   (sr_wr_req),
    .arr_ok   (arr_ok),
    .sr_ok    (sr_ok),
    .refuse   (refuse)
  );

  assign accept = arr_ok | sr_ok;

  srwp_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy),
    .done  (done)
  );

  always_comb begin
    wpen_d  = wpen_q;
    lock_d  = lock_q;
    flag_d  = flag_q;
    wel_d   = wel_q;
    pend_d  = pend_q;
    stage_d = stage_q;
    if (busy) begin
      if (done) begin
        wel_d  = 1'b0;
        pend_d = PEND_NONE;
        if (pend_q == PEND_SR) begin
          wpen_d = stage_q[2];
          lock_d = lock_e'(stage_q[1:0]);
        end
      end
    end else begin
      if (wel_clr)       wel_d = 1'b0;
      else if (wel_set)  wel_d = 1'b1;
      if (flag_clr)      flag_d = 1'b0;
      else if (flag_set) flag_d = 1'b1;
      if (arr_ok) pend_d = PEND_ARR;
      if (sr_ok) begin
        pend_d  = PEND_SR;
        stage_d = {sr_wr_data[SB_WPEN], sr_wr_data[SB_BL1], sr_wr_data[SB_BL0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpen_q  <= 1'b0;
      lock_q  <= LOCK_NONE;
      flag_q  <= 1'b0;
      wel_q   <= 1'b0;
      pend_q  <= PEND_NONE;
      stage_q <= '0;
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      wpen_q  <= wpen_d;
      lock_q  <= lock_d;
      flag_q  <= flag_d;
      wel_q   <= wel_d;
      pend_q  <= pend_d;
      stage_q <= stage_d;
      grant_q <= accept;
      deny_q  <= refuse;
    end
  end

  assign wr_grant    = grant_q;
  assign wr_deny     = deny_q;
  assign status_byte = {wpen_q, flag_q, 2'b00, lock_q, wel_q, busy};
endmodule

// File: rtl/srwp_unit_chk.sv
module srwp_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_pin,
  input logic       arr_wr_req,
  input logic       sr_wr_req,
  input logic       wr_grant,
  input logic       wr_deny,
  input logic [7:0] status_byte
);
  AST_ZERO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[5:4] == 2'b00); // R1

  AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_grant && wr_deny)); // R10

  AST_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> status_byte[0]); // R8

  AST_DENY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_deny |-> !status_byte[0]); // R10

  AST_DENY_WEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_deny |-> (status_byte[1] == $past(status_byte[1]))); // R10

  AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_byte[0]) |-> !status_byte[1]); // R8

  AST_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_req && status_byte[3:2] == 2'b11 && !status_byte[0]) |=> wr_deny); // R6

  AST_ROM_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_req && !arr_wr_req && status_byte[7] && !wp_pin && !status_byte[0]) |=> wr_deny); // R7

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[0] |=> (!wr_grant && !wr_deny)); // R11
endmodule

bind srwp_unit srwp_unit_chk u_chk (.*);

// File: tb/srwp_unit_test.sv
`timescale 1ns/1ps
module srwp_unit_test;
  localparam int AW = 11;
  localparam int WR = 6;
  localparam int NVEC = 11;
  // entry: {lock code[1:0], address[10:0], expect grant}
  localparam logic [13:0] LOCK_VEC [NVEC] = '{
    {2'b00, 11'h000, 1'b1},
    {2'b00, 11'h7FF, 1'b1},
    {2'b01, 11'h5FF, 1'b1},
    {2'b01, 11'h600, 1'b0},
    {2'b01, 11'h7FF, 1'b0},
    {2'b10, 11'h3FF, 1'b1},
    {2'b10, 11'h400, 1'b0},
    {2'b10, 11'h5FF, 1'b0},
    {2'b11, 11'h000, 1'b0},
    {2'b11, 11'h3FF, 1'b0},
    {2'b00, 11'h400, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, wp_pin = 1'b1;
  logic wel_set = 1'b0, wel_clr = 1'b0, flag_set = 1'b0, flag_clr = 1'b0;
  logic arr_wr_req = 1'b0, sr_wr_req = 1'b0;
  logic [AW-1:0] arr_wr_addr = '0;
  logic [7:0] sr_wr_data = '0;
  logic wr_grant, wr_deny;
  logic [7:0] status_byte;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  srwp_unit #(.ADDR_W(AW), .WR_CYCLES(WR)) uut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input int sel);
    case (sel)
      0: wel_set = 1'b1;
      1: wel_clr = 1'b1;
      2: flag_set = 1'b1;
      default: flag_clr = 1'b1;
    endcase
    @(negedge clk);
    wel_set = 1'b0; wel_clr = 1'b0; flag_set = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic arr_req(input logic [AW-1:0] a);
    arr_wr_req = 1'b1; arr_wr_addr = a;
    @(negedge clk);
    arr_wr_req = 1'b0;
  endtask

  task automatic sr_req(input logic [7:0] d);
    sr_wr_req = 1'b1; sr_wr_data = d;
    @(negedge clk);
    sr_wr_req = 1'b0;
  endtask

  // called on the sample right after the granting edge
  task automatic wait_done(input string req);
    chk(req, {7'b0, status_byte[0]}, 8'h01);
    for (int i = 1; i < WR; i++) begin
      @(negedge clk);
      chk(req, {7'b0, status_byte[0]}, 8'h01);
    end
    @(negedge clk);
    chk(req, {6'b0, status_byte[1:0]}, 8'h00);
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    if (!finished) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [1:0] cur_bl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 status", status_byte, 8'h00);
    chk("R2 pulses", {6'b0, wr_grant, wr_deny}, 8'h00);

    pulse(0); chk("R3 set", status_byte, 8'h02);
    pulse(1); chk("R3 clear", status_byte, 8'h00);
    wel_set = 1'b1; pulse(1); chk("R3 clear wins", status_byte, 8'h00);
    pulse(2); chk("R4 set", status_byte, 8'h40);
    pulse(3); chk("R4 clear", status_byte, 8'h00);

    arr_req('0);
    chk("R5 arr deny", {6'b0, wr_grant, wr_deny}, 8'h01);
    chk("R10 arr status", status_byte, 8'h00);
    sr_req(8'hFF);
    chk("R5 sr deny", {6'b0, wr_grant, wr_deny}, 8'h01);
    chk("R10 sr status", status_byte, 8'h00);

    pulse(2); pulse(0);
    chk("R1 flag wel", status_byte, 8'h42);
    sr_req(8'hFF);
    chk("R8 grant", {6'b0, wr_grant, wr_deny}, 8'h02);
    chk("R8 busy", status_byte, 8'h43);
    pulse(1); chk("R11 wel ignored", status_byte, 8'h43);
    pulse(3); chk("R11 flag ignored", status_byte, 8'h43);
    arr_req('0); chk("R11 req ignored", {6'b0, wr_grant, wr_deny}, 8'h00);
    @(negedge clk); chk("R8 still busy", status_byte, 8'h43);
    @(negedge clk); chk("R8 last busy", status_byte, 8'h43);
    @(negedge clk); chk("R8 R4 stored bits", status_byte, 8'hCC);

    wp_pin = 1'b0;
    pulse(0); chk("R3 set again", status_byte, 8'hCE);
    sr_req(8'h00);
    chk("R7 rom deny", {6'b0, wr_grant, wr_deny}, 8'h01);
    chk("R10 wel kept", status_byte, 8'hCE);

    wp_pin = 1'b1;
    sr_req(8'h00);
    chk("R7 pin high grant", {6'b0, wr_grant, wr_deny}, 8'h02);
    wp_pin = 1'b0;
    wait_done("R9 busy window");
    chk("R9 completes", status_byte, 8'h40);

    pulse(0);
    sr_req(8'h80);
    chk("R7 wpen0 pin low", {6'b0, wr_grant, wr_deny}, 8'h02);
    wait_done("R8 window");
    chk("R8 wpen stored", status_byte, 8'hC0);

    pulse(0);
    sr_req(8'h0C);
    chk("R7 rom deny 2", {6'b0, wr_grant, wr_deny}, 8'h01);
    chk("R7 status kept", status_byte, 8'hC2);
    wp_pin = 1'b1;
    sr_req(8'h00);
    chk("R7 unlock grant", {6'b0, wr_grant, wr_deny}, 8'h02);
    wait_done("R8 window 2");
    chk("R8 cleared", status_byte, 8'h40);
    pulse(3); chk("R4 clear 2", status_byte, 8'h00);

    cur_bl = 2'b00;
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] bl;
      logic [AW-1:0] a;
      logic ok;
      {bl, a, ok} = LOCK_VEC[v];
      if (bl != cur_bl) begin
        pulse(0);
        sr_req({4'b0, bl, 2'b0});
        chk("R6 lock program", {6'b0, wr_grant, wr_deny}, 8'h02);
        wait_done("R6 lock window");
        chk("R6 lock code", {6'b0, status_byte[3:2]}, {6'b0, bl});
        cur_bl = bl;
      end
      pulse(0);
      arr_req(a);
      chk($sformatf("R6 lock %b addr %h", bl, a), {6'b0, wr_grant, wr_deny}, ok ? 8'h02 : 8'h01);
      if (ok) begin
        wait_done("R8 array window");
      end else begin
        chk("R10 deny keeps wel", {6'b0, status_byte[1:0]}, 8'h02);
        pulse(1);
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule